// File: doc/BRIEF.md
# Carrier Lock Detector

This block decides whether a carrier tracking loop has acquired and is holding lock. It works in evaluation intervals. Within each interval, a lock-metric accumulator adds the magnitude supplied with every sample strobe, and an interval counter counts the same strobes. The interval ends as soon as either one reaches its programmed limit. The block records which of the two got there first. When the accumulator reaches its threshold first, the loop is showing strong coherent energy. When the counter expires first, the loop is not.

A four-state controller acts on these interval results. The states are search, verify, lock and false lock. The verify phase runs a fixed number of intervals before lock can be declared. The lock phase runs in windows of a fixed number of intervals, and lock is only given up at the end of a window. While locked, a second accumulator sums the metric over the whole window. If that sum reaches its own threshold before the window closes, the loop is judged to be falsely locked. The block then spends one interval in the false-lock state, pulses a flag so the loop can be re-steered, and returns to search.

All limits come in on configuration inputs. They are captured while reset is held and kept for the rest of the run.

Top module: `lockdet_top`

## Requirements
- R1: While `rst` is high, the block captures the five configuration inputs. After reset, `lock_state` is 0, `locked` and `false_lock` are 0, and `acc_value` and `icnt_value` are 0. Changes on the configuration inputs after reset has been released have no effect.
- R2: Each sample with `smp_valid` high adds `smp_mag` to `acc_value` and adds 1 to `icnt_value`. A cycle with `smp_valid` low leaves both values unchanged.
- R3: An interval ends on the sample where accumulator plus magnitude is at least `cfg_acc_thresh` (an accumulator win), or where the incremented count is at least `cfg_int_len` (a counter win). If both happen on the same sample, the accumulator wins. Both values read 0 in the cycle after an interval ends.
- R4: In search (code 0), a counter win keeps the state in search, and an accumulator win moves it to verify (code 1).
- R5: Verify lasts exactly `cfg_verify_len` intervals. At the end of the last of them, an accumulator win moves to lock (code 2) and a counter win returns to search.
- R6: Lock runs in windows of `cfg_lock_len` intervals. At the last interval of a window, a counter win returns to search. An accumulator win starts a new window and clears the false-lock sum. Before the last interval, the state stays in lock whatever the interval results.
- R7: In lock, every valid sample adds `smp_mag` to a false-lock sum. The sample on which that sum reaches `cfg_fl_thresh` moves the state to false lock (code 3) and clears the interval accumulator and counter. This takes priority over any interval result on the same sample.
- R8: False lock lasts until the next interval end and then returns to search. `false_lock` is high for exactly one cycle: the first cycle in which the state reads 3.
- R9: `locked` is high exactly when `lock_state` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| smp_valid | input | 1 | Sample strobe |
| smp_mag | input | MAG_W | Lock metric magnitude of the current sample |
| cfg_acc_thresh | input | ACC_W | Interval accumulator threshold |
| cfg_int_len | input | CNT_W | Interval length in samples |
| cfg_verify_len | input | RUN_W | Intervals spent in verify |
| cfg_lock_len | input | RUN_W | Intervals per lock window |
| cfg_fl_thresh | input | ACC_W | False-lock sum threshold |
| lock_state | output | 2 | Controller state: 0 search, 1 verify, 2 lock, 3 false lock |
| locked | output | 1 | High in the lock state |
| false_lock | output | 1 | One-cycle pulse on entry to false lock |
| acc_value | output | ACC_W | Interval accumulator |
| icnt_value | output | CNT_W | Interval sample counter |

## Verification
The bench uses the default widths. Configuration is captured during reset with an accumulator threshold of 20, an interval of 4 samples, a verify run of 2 intervals, a lock window of 3 intervals and a false-lock threshold of 200. It then drives quite different values onto the configuration pins, so every later result also shows that the captured settings are the ones in use.

These short limits make a complete pass through the states fit in a few dozen samples. That pass covers:
- a tie between the accumulator and the counter;
- both verify outcomes;
- window expiry and window restart in lock;
- a false-lock sum landing exactly on its threshold.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCK   = 2'd2,
        ST_FALSE  = 2'd3
    } lk_state_e;

    // Outcome of one evaluation interval.
    typedef struct packed {
        logic done;     // interval closed on this sample
        logic acc_won;  // accumulator reached its limit first (or tied)
    } race_res_t;

endpackage

// File: rtl/lockdet_race.sv
`timescale 1ns/1ps
module lockdet_race #(
    parameter int MAG_W = 8,
    parameter int ACC_W = 16,
    parameter int CNT_W = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        valid,
    input  logic [MAG_W-1:0]            mag,
    input  logic [ACC_W-1:0]            thresh,
    input  logic [CNT_W-1:0]            len,
    input  logic                        restart,
    output logic [ACC_W-1:0]            acc,
    output logic [CNT_W-1:0]            icnt,
    output lockdet_pkg::race_res_t      res
);
    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] icnt_nxt;
    logic             acc_hit;
    logic             cnt_hit;

    always_comb begin
        sum      = {1'b0, acc} + SUM_W'(mag);
        icnt_nxt = icnt + CNT_W'(1);
        acc_hit  = sum >= {1'b0, thresh};
        cnt_hit  = icnt_nxt >= len;
        res.done    = valid && (acc_hit || cnt_hit);
        res.acc_won = acc_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || res.done) begin
            acc  <= '0;
            icnt <= '0;
        end else if (valid) begin
            acc  <= sum[ACC_W-1:0];
            icnt <= icnt_nxt;
        end
    end
endmodule

// File: rtl/lockdet_ctrl.sv
`timescale 1ns/1ps
module lockdet_ctrl #(
    parameter int MAG_W = 8,
    parameter int ACC_W = 16,
    parameter int RUN_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        valid,
    input  logic [MAG_W-1:0]            mag,
    input  lockdet_pkg::race_res_t      race,
    input  logic [RUN_W-1:0]            verify_len,
    input  logic [RUN_W-1:0]            lock_len,
    input  logic [ACC_W-1:0]            fl_thresh,
    output lockdet_pkg::lk_state_e      state,
    output logic                        restart,
    output logic                        false_lock
);
    import lockdet_pkg::*;
    localparam int SUM_W = ACC_W + 1;

    lk_state_e        st_n;
    logic [RUN_W-1:0] vcnt, vcnt_n, lcnt, lcnt_n;
    logic [ACC_W-1:0] flacc, flacc_n;
    logic [SUM_W-1:0] fl_sum;
    logic             fl_hit, vdone, ldone;

    always_comb begin
        fl_sum  = {1'b0, flacc} + SUM_W'(mag);
        fl_hit  = valid && (state == ST_LOCK) && (fl_sum >= {1'b0, fl_thresh});
        vdone   = (vcnt + RUN_W'(1)) >= verify_len;
        ldone   = (lcnt + RUN_W'(1)) >= lock_len;
        st_n    = state;
        vcnt_n  = vcnt;
        lcnt_n  = lcnt;
        flacc_n = flacc;
        restart = 1'b0;
        case (state)
            ST_SEARCH: begin
                if (race.done && race.acc_won) begin
                    st_n   = ST_VERIFY;
                    vcnt_n = '0;
                end
            end
            ST_VERIFY: begin
                if (race.done) begin
                    if (vdone) begin
                        st_n    = race.acc_won ? ST_LOCK : ST_SEARCH;
                        lcnt_n  = '0;
                        flacc_n = '0;
                    end else begin
                        vcnt_n = vcnt + RUN_W'(1);
                    end
                end
            end
            ST_LOCK: begin
                if (fl_hit) begin
                    st_n    = ST_FALSE;
                    restart = 1'b1;
                end else begin
                    if (valid)
                        flacc_n = fl_sum[ACC_W-1:0];
                    if (race.done) begin
                        if (ldone) begin
                            if (!race.acc_won)
                                st_n = ST_SEARCH;
                            lcnt_n  = '0;
                            flacc_n = '0;
                        end else begin
                            lcnt_n = lcnt + RUN_W'(1);
                        end
                    end
                end
            end
            default: begin
                if (race.done)
                    st_n = ST_SEARCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_SEARCH;
            vcnt       <= '0;
            lcnt       <= '0;
            flacc      <= '0;
            false_lock <= 1'b0;
        end else begin
            state      <= st_n;
            vcnt       <= vcnt_n;
            lcnt       <= lcnt_n;
            flacc      <= flacc_n;
            false_lock <= restart;
        end
    end
endmodule

// File: rtl/lockdet_top.sv
`timescale 1ns/1ps
module lockdet_top #(
    parameter int MAG_W = 8,
    parameter int ACC_W = 16,
    parameter int CNT_W = 12,
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [MAG_W-1:0] smp_mag,
    input  logic [ACC_W-1:0] cfg_acc_thresh,
    input  logic [CNT_W-1:0] cfg_int_len,
    input  logic [RUN_W-1:0] cfg_verify_len,
    input  logic [RUN_W-1:0] cfg_lock_len,
    input  logic [ACC_W-1:0] cfg_fl_thresh,
    output logic [1:0]       lock_state,
    output logic             locked,
    output logic             false_lock,
    output logic [ACC_W-1:0] acc_value,
    output logic [CNT_W-1:0] icnt_value
);
    import lockdet_pkg::*;

    logic [ACC_W-1:0] acc_thr_q, fl_thr_q;
    logic [CNT_W-1:0] int_len_q;
    logic [RUN_W-1:0] ver_len_q, lock_len_q;
    race_res_t        race;
    lk_state_e        state;
    logic             restart;

    // Settings are latched only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_thr_q  <= cfg_acc_thresh;
            int_len_q  <= cfg_int_len;
            ver_len_q  <= cfg_verify_len;
            lock_len_q <= cfg_lock_len;
            fl_thr_q   <= cfg_fl_thresh;
        end
    end

    lockdet_race #(.MAG_W(MAG_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_race (
        .clk(clk), .rst(rst), .valid(smp_valid), .mag(smp_mag),
        .thresh(acc_thr_q), .len(int_len_q), .restart(restart),
        .acc(acc_value), .icnt(icnt_value), .res(race)
    );

    lockdet_ctrl #(.MAG_W(MAG_W), .ACC_W(ACC_W), .RUN_W(RUN_W)) u_ctrl (
        .clk(clk), .rst(rst), .valid(smp_valid), .mag(smp_mag), .race(race),
        .verify_len(ver_len_q), .lock_len(lock_len_q), .fl_thresh(fl_thr_q),
        .state(state), .restart(restart), .false_lock(false_lock)
    );

    assign lock_state = state;
    assign locked     = (state == ST_LOCK);
endmodule

// File: rtl/lockdet_checks.sv
`timescale 1ns/1ps
module lockdet_checks #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic [1:0]       lock_state,
    input logic             locked,
    input logic             false_lock,
    input logic [ACC_W-1:0] acc_value,
    input logic [CNT_W-1:0] icnt_value,
    input logic [ACC_W-1:0] acc_thr_q
);
    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lock_state == 2'd0 && acc_value == '0 && icnt_value == '0 && !false_lock));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(acc_value) && $stable(icnt_value)));

    assert_acc_below_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_thr_q != '0) |-> (acc_value < acc_thr_q));

    assert_search_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_state == 2'd0) |=> (lock_state == 2'd0 || lock_state == 2'd1));

    assert_verify_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (lock_state == 2'd1) |=> (lock_state != 2'd3));

    assert_false_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (lock_state == 2'd3 && $past(lock_state) != 2'd3) |-> ($past(lock_state) == 2'd2));

    assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        false_lock |=> !false_lock);

    assert_pulse_state_R8: assert property (@(posedge clk) disable iff (rst)
        false_lock |-> (lock_state == 2'd3 && !locked));

    assert_locked_R9: assert property (@(posedge clk) disable iff (rst)
        locked |-> (lock_state == 2'd2));
endmodule

bind lockdet_top lockdet_checks #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .lock_state(lock_state),
    .locked(locked), .false_lock(false_lock), .acc_value(acc_value),
    .icnt_value(icnt_value), .acc_thr_q(acc_thr_q)
);

// File: tb/lockdet_top_test.sv
`timescale 1ns/1ps
module lockdet_top_test;
    localparam int MAG_W = 8;
    localparam int ACC_W = 16;
    localparam int CNT_W = 12;
    localparam int RUN_W = 8;
    localparam int NVEC  = 38;

    typedef struct packed {
        logic             v;
        logic [7:0]       mag;
        logic [1:0]       st;
        logic             fl;
        logic [15:0]      acc;
        logic [11:0]      ic;
        logic [3:0]       req;
    } vec_t;

    // Captured config: acc 20, interval 4, verify 2, lock window 3, false-lock 200.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,8'd5,  2'd0,1'b0,16'd5, 12'd1,4'd2},  // R2 add
        '{1'b0,8'd50, 2'd0,1'b0,16'd5, 12'd1,4'd2},  // R2 no strobe
        '{1'b1,8'd5,  2'd0,1'b0,16'd10,12'd2,4'd2},
        '{1'b1,8'd5,  2'd0,1'b0,16'd15,12'd3,4'd2},
        '{1'b1,8'd4,  2'd0,1'b0,16'd0, 12'd0,4'd4},  // R4 counter win stays
        '{1'b1,8'd25, 2'd1,1'b0,16'd0, 12'd0,4'd4},  // R4 acc win -> verify
        '{1'b1,8'd3,  2'd1,1'b0,16'd3, 12'd1,4'd5},
        '{1'b1,8'd3,  2'd1,1'b0,16'd6, 12'd2,4'd5},
        '{1'b1,8'd3,  2'd1,1'b0,16'd9, 12'd3,4'd5},
        '{1'b1,8'd3,  2'd1,1'b0,16'd0, 12'd0,4'd5},  // R5 first verify interval
        '{1'b1,8'd30, 2'd2,1'b0,16'd0, 12'd0,4'd5},  // R5 -> lock
        '{1'b1,8'd20, 2'd2,1'b0,16'd0, 12'd0,4'd6},
        '{1'b1,8'd20, 2'd2,1'b0,16'd0, 12'd0,4'd6},
        '{1'b1,8'd1,  2'd2,1'b0,16'd1, 12'd1,4'd6},
        '{1'b1,8'd1,  2'd2,1'b0,16'd2, 12'd2,4'd6},
        '{1'b1,8'd1,  2'd2,1'b0,16'd3, 12'd3,4'd6},
        '{1'b1,8'd1,  2'd0,1'b0,16'd0, 12'd0,4'd6},  // R6 loss at window end
        '{1'b1,8'd5,  2'd0,1'b0,16'd5, 12'd1,4'd3},
        '{1'b1,8'd5,  2'd0,1'b0,16'd10,12'd2,4'd3},
        '{1'b1,8'd5,  2'd0,1'b0,16'd15,12'd3,4'd3},
        '{1'b1,8'd5,  2'd1,1'b0,16'd0, 12'd0,4'd3},  // R3 tie goes to accumulator
        '{1'b1,8'd20, 2'd1,1'b0,16'd0, 12'd0,4'd5},
        '{1'b1,8'd20, 2'd2,1'b0,16'd0, 12'd0,4'd5},
        '{1'b1,8'd20, 2'd2,1'b0,16'd0, 12'd0,4'd6},
        '{1'b1,8'd20, 2'd2,1'b0,16'd0, 12'd0,4'd6},
        '{1'b1,8'd20, 2'd2,1'b0,16'd0, 12'd0,4'd6},  // R6 window restart
        '{1'b1,8'd19, 2'd2,1'b0,16'd19,12'd1,4'd6},
        '{1'b1,8'd150,2'd2,1'b0,16'd0, 12'd0,4'd6},  // R6 sum was cleared
        '{1'b1,8'd31, 2'd3,1'b1,16'd0, 12'd0,4'd7},  // R7 exact threshold
        '{1'b0,8'd0,  2'd3,1'b0,16'd0, 12'd0,4'd8},  // R8 single pulse
        '{1'b1,8'd2,  2'd3,1'b0,16'd2, 12'd1,4'd8},
        '{1'b1,8'd30, 2'd0,1'b0,16'd0, 12'd0,4'd8},  // R8 back to search
        '{1'b1,8'd25, 2'd1,1'b0,16'd0, 12'd0,4'd5},
        '{1'b1,8'd25, 2'd1,1'b0,16'd0, 12'd0,4'd5},
        '{1'b1,8'd1,  2'd1,1'b0,16'd1, 12'd1,4'd5},
        '{1'b1,8'd1,  2'd1,1'b0,16'd2, 12'd2,4'd5},
        '{1'b1,8'd1,  2'd1,1'b0,16'd3, 12'd3,4'd5},
        '{1'b1,8'd1,  2'd0,1'b0,16'd0, 12'd0,4'd5}   // R5 counter win at end
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic [MAG_W-1:0] smp_mag = '0;
    logic [ACC_W-1:0] cfg_acc_thresh = 16'd20;
    logic [CNT_W-1:0] cfg_int_len = 12'd4;
    logic [RUN_W-1:0] cfg_verify_len = 8'd2;
    logic [RUN_W-1:0] cfg_lock_len = 8'd3;
    logic [ACC_W-1:0] cfg_fl_thresh = 16'd200;
    logic [1:0]       lock_state;
    logic             locked, false_lock;
    logic [ACC_W-1:0] acc_value;
    logic [CNT_W-1:0] icnt_value;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lockdet_top #(.MAG_W(MAG_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .RUN_W(RUN_W)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_mag(smp_mag),
        .cfg_acc_thresh(cfg_acc_thresh), .cfg_int_len(cfg_int_len),
        .cfg_verify_len(cfg_verify_len), .cfg_lock_len(cfg_lock_len),
        .cfg_fl_thresh(cfg_fl_thresh), .lock_state(lock_state), .locked(locked),
        .false_lock(false_lock), .acc_value(acc_value), .icnt_value(icnt_value)
    );

    task automatic check(input string tag, input logic [1:0] st, input logic fl,
                         input logic [15:0] acc, input logic [11:0] ic);
        total++;
        if (lock_state !== st || false_lock !== fl || acc_value !== acc ||
            icnt_value !== ic || locked !== (st == 2'd2)) begin
            bad++;
            $display("FAIL %s: st=%0d fl=%0d lk=%0d acc=%0d ic=%0d expected st=%0d fl=%0d lk=%0d acc=%0d ic=%0d",
                     tag, lock_state, false_lock, locked, acc_value, icnt_value,
                     st, fl, (st == 2'd2), acc, ic);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] m);
        @(negedge clk);
        smp_valid = v;
        smp_mag   = m;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset state", 2'd0, 1'b0, 16'd0, 12'd0);
        @(negedge clk);
        rst = 1'b0;
        // R1: settings changed after reset must be ignored.
        cfg_acc_thresh = 16'd1000;
        cfg_int_len    = 12'd1;
        cfg_verify_len = 8'd9;
        cfg_lock_len   = 8'd9;
        cfg_fl_thresh  = 16'd5;
        @(posedge clk);
        #2;
        check("R1 idle after release", 2'd0, 1'b0, 16'd0, 12'd0);

        // R2..R9 walked by the vector table; locked checked on every row (R9).
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].v, VECS[i].mag);
            check($sformatf("R%0d row %0d (R9 locked)", VECS[i].req, i),
                  VECS[i].st, VECS[i].fl, VECS[i].acc, VECS[i].ic);
        end

        // R1: reset mid-interval in verify clears everything.
        step(1'b1, 8'd25);
        step(1'b1, 8'd5);
        check("R1 before reset", 2'd1, 1'b0, 16'd5, 12'd1);
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        @(posedge clk);
        #2;
        check("R1 reset mid-run", 2'd0, 1'b0, 16'd0, 12'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule